// File: doc/BRIEF.md
# Wide-Address Fetch and Indirect-Jump Sequencer

A small accumulator-style processor front end that drives a 32-bit byte address bus. It makes one memory access per clock. Memory is an outside byte-wide model that returns `din` for the current `addr` within the same cycle. The core captures that byte on the next rising edge.

Only three things are implemented: the start-up vector load, the load-X-immediate instruction (opcode 0xA2) and the absolute X-indexed indirect jump (opcode 0x7C). Every other opcode is skipped as a one-cycle no-operation. Each absolute operand, pointer and vector is four bytes, least significant byte first, read on consecutive cycles. The `rdy` input freezes the core in place.

Top module: `wide_fetch_core`

## Requirements
- R1: While `rst` is high, `addr` is 0xFFFFFFF4 and `we` is 0. After release, five idle cycles drive 0xFFFFFFF4. The next four cycles read 0xFFFFFFF4 to 0xFFFFFFF7, which makes nine start-up cycles.
- R2: The four start-up bytes, least significant first, form the address of the first opcode fetch. That fetch happens on the cycle after the last vector byte.
- R3: Opcode 0xA2 fetched at P is followed by a read of its operand at P+1. The byte read at P+1 is loaded into X. The next opcode fetch is at P+2.
- R4: Opcode 0x7C fetched at P is followed by reads at P+1, P+2, P+3 and P+4, in that order. These bytes form a 32-bit base, least significant byte first.
- R5: On the cycle right after the last operand byte, the core reads base+X, base+X+1, base+X+2 and base+X+3. X is zero-extended, and the sums wrap modulo 2^32.
- R6: The four pointer bytes, least significant first, are the jump target. The opcode fetch at the target is on the very next cycle.
- R7: `we` is 0 and `dout` is 0 in every cycle.
- R8: While `rdy` is low, `addr` and all internal progress hold. After `rdy` returns high, the sequence resumes with no address skipped.
- R9: Any opcode other than 0xA2 and 0x7C takes one cycle. The next fetch is at the following address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rdy | input | 1 | Progress enable; low stalls the core |
| din | input | 8 | Byte returned by memory for the current `addr` |
| addr | output | 32 | Byte address of the current bus cycle |
| we | output | 1 | Write enable (always low for this instruction subset) |
| dout | output | 8 | Write data (always zero) |

## Verification
The assertions assume that `din` is a pure function of the current `addr` and is valid before the next rising edge. They also assume that `rdy` changes only between edges. The bench meets both assumptions. It computes memory contents combinationally from the address and a few per-case variables, and it drives `rdy` and `rst` only on falling edges. Program, pointer and vector regions are placed so that they never overlap. Because of this, each expected address depends only on the case parameters, including the case where base plus X wraps past the top of the address space.

// File: rtl/wide_fetch_core.sv
module wide_fetch_core #(
  parameter int AW = 32,
  parameter logic [31:0] VEC = 32'hFFFF_FFF4,
  parameter int BOOT_IDLE = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rdy,
  input  logic [7:0]    din,
  output logic [AW-1:0] addr,
  output logic          we,
  output logic [7:0]    dout
);
  localparam int NB = AW / 8;
  localparam int IW = $clog2(NB);
  localparam int CW = $clog2(BOOT_IDLE + 1);
  localparam logic [2:0] S_BOOT = 3'd0, S_VEC = 3'd1, S_FETCH = 3'd2,
                         S_IMM = 3'd3, S_OPR = 3'd4, S_PTR = 3'd5;
  localparam logic [7:0] OP_LDX = 8'hA2, OP_JIX = 8'h7C;

  logic [2:0]    state;
  logic [IW-1:0] idx;
  logic [CW-1:0] boot;
  logic [AW-1:0] pc, base, tmp;
  logic [7:0]    x;
  logic          last;

  assign we   = 1'b0;
  assign dout = 8'h00;
  assign last = (idx == IW'(NB - 1));

  always_comb begin
    case (state)
      S_BOOT:  addr = AW'(VEC);
      S_VEC:   addr = AW'(VEC) + AW'(idx);
      S_PTR:   addr = base + {{(AW-8){1'b0}}, x} + AW'(idx);
      default: addr = pc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_BOOT;
      boot  <= '0;
      idx   <= '0;
      pc    <= '0;
      base  <= '0;
      tmp   <= '0;
      x     <= '0;
    end else if (rdy) begin
      case (state)
        S_BOOT: begin
          if (boot == CW'(BOOT_IDLE - 1)) begin
            state <= S_VEC;
            idx   <= '0;
          end else begin
            boot <= boot + 1'b1;
          end
        end
        S_VEC: begin
          tmp <= {din, tmp[AW-1:8]};
          idx <= idx + 1'b1;
          if (last) begin
            pc    <= {din, tmp[AW-1:8]};
            state <= S_FETCH;
          end
        end
        S_FETCH: begin
          pc <= pc + 1'b1;
          if (din == OP_LDX) state <= S_IMM;
          else if (din == OP_JIX) begin
            state <= S_OPR;
            idx   <= '0;
          end
        end
        S_IMM: begin
          x     <= din;
          pc    <= pc + 1'b1;
          state <= S_FETCH;
        end
        S_OPR: begin
          base <= {din, base[AW-1:8]};
          pc   <= pc + 1'b1;
          idx  <= idx + 1'b1;
          if (last) state <= S_PTR;
        end
        S_PTR: begin
          tmp <= {din, tmp[AW-1:8]};
          idx <= idx + 1'b1;
          if (last) begin
            pc    <= {din, tmp[AW-1:8]};
            state <= S_FETCH;
          end
        end
        default: state <= S_BOOT;
      endcase
    end
  end
endmodule

module wide_fetch_chk #(
  parameter int AW = 32,
  parameter int IW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          rdy,
  input logic [7:0]    din,
  input logic [AW-1:0] addr,
  input logic          we,
  input logic [7:0]    dout,
  input logic [2:0]    state,
  input logic [IW-1:0] idx,
  input logic [AW-1:0] tmp
);
  localparam logic [2:0] S_FETCH = 3'd2, S_IMM = 3'd3, S_PTR = 3'd5;
  localparam logic [IW-1:0] LAST = '1;

  p_write_off_r7: assert property (@(posedge clk) disable iff (rst)
    (we == 1'b0) && (dout == 8'h00));

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !rdy |=> $stable(addr));

  p_ldx_operand_r3: assert property (@(posedge clk) disable iff (rst)
    (state == S_FETCH && rdy && din == 8'hA2) |=> (state == S_IMM && addr == $past(addr) + 1'b1));

  p_ptr_step_r5: assert property (@(posedge clk) disable iff (rst)
    (state == S_PTR && rdy && idx != LAST) |=> (addr == $past(addr) + 1'b1));

  p_jump_target_r6: assert property (@(posedge clk) disable iff (rst)
    (state == S_PTR && rdy && idx == LAST) |=> (state == S_FETCH && addr == {$past(din), $past(tmp[AW-1:8])}));

  p_skip_op_r9: assert property (@(posedge clk) disable iff (rst)
    (state == S_FETCH && rdy && din != 8'hA2 && din != 8'h7C) |=> (state == S_FETCH && addr == $past(addr) + 1'b1));
endmodule

bind wide_fetch_core wide_fetch_chk #(.AW(AW), .IW(IW)) u_chk (
  .clk(clk), .rst(rst), .rdy(rdy), .din(din), .addr(addr), .we(we),
  .dout(dout), .state(state), .idx(idx), .tmp(tmp)
);

// File: tb/sim_wide_fetch_core.sv
module sim_wide_fetch_core;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] VEC = 32'hFFFF_FFF4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rdy = 1'b1;
  logic [7:0]  din, dout;
  logic [31:0] addr;
  logic        we;

  logic [31:0] p_v = 32'h200, b_v = 32'h0, t_v = 32'h0;
  logic [7:0]  x_v = 8'h0;
  logic [31:0] expq [0:31];
  int checks = 0, fails = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wide_fetch_core u0 (.clk(clk), .rst(rst), .rdy(rdy), .din(din),
                      .addr(addr), .we(we), .dout(dout));

  function automatic logic [7:0] mem_byte(input logic [31:0] a, p, b, t, input logic [7:0] xv);
    logic [31:0] o, sh;
    o = a - VEC;
    if (o < 4) begin sh = p >> (o * 8); return sh[7:0]; end
    o = a - p;
    if (o < 7) begin
      case (o)
        0: return 8'hA2;
        1: return xv;
        2: return 8'h7C;
        default: begin sh = b >> ((o - 3) * 8); return sh[7:0]; end
      endcase
    end
    o = a - (b + {24'h0, xv});
    if (o < 4) begin sh = t >> (o * 8); return sh[7:0]; end
    return 8'hEA;
  endfunction

  assign din = mem_byte(addr, p_v, b_v, t_v, x_v);

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      fails = fails + 1;
      $display("FAIL watchdog expired act=%0d exp<=100000", cycles);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input int k);
    if (k < 5) return "R1 idle";
    if (k < 9) return "R1 vector read";
    if (k == 9) return "R2 first fetch";
    if (k == 10) return "R3 ldx operand";
    if (k == 11) return "R3 next fetch";
    if (k < 16) return "R4 operand";
    if (k < 20) return "R5 pointer";
    if (k == 20) return "R6 target fetch";
    return "R9 skip op";
  endfunction

  task automatic run_case(input logic [31:0] p, input logic [7:0] xv,
                          input logic [31:0] b, input logic [31:0] t,
                          input int stall);
    int n;
    @(negedge clk);
    rst = 1'b1; rdy = 1'b1;
    p_v = p; x_v = xv; b_v = b; t_v = t;
    repeat (2) @(negedge clk);
    chk("R1 addr in reset", addr, VEC);
    chk("R7 we in reset", {31'h0, we}, 32'h0);
    n = 0;
    for (int i = 0; i < 5; i++) expq[n++] = VEC;
    for (int i = 0; i < 4; i++) expq[n++] = VEC + i;
    expq[n++] = p; expq[n++] = p + 1; expq[n++] = p + 2;
    for (int i = 3; i < 7; i++) expq[n++] = p + i;
    for (int i = 0; i < 4; i++) expq[n++] = b + {24'h0, xv} + i;
    for (int i = 0; i < 3; i++) expq[n++] = t + i;
    rst = 1'b0;
    for (int k = 0; k < n; k++) begin
      #1;
      chk(tag_of(k), addr, expq[k]);
      chk("R7 we/dout", {23'h0, we, dout}, 32'h0);
      if (k == stall) begin
        rdy = 1'b0;
        repeat (2) begin
          @(negedge clk); #1;
          chk("R8 stall hold", addr, expq[k]);
        end
        rdy = 1'b1;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    run_case(32'h0000_0200, 8'h01, 32'hDEAD_BEEF, 32'hBEEF_B055, -1);
    run_case(32'h0000_1000, 8'h00, 32'h0040_0000, 32'h1234_5678, 3);
    run_case(32'h8000_0000, 8'hFF, 32'h1000_0000, 32'hFFFF_FFF0, 14);
    run_case(32'h0000_3000, 8'h05, 32'hFFFF_FFFD, 32'h0000_7000, 18);
    run_case(32'h0000_4000, 8'h80, 32'h0000_0100, 32'h00AB_CDEF, 9);
    run_case(32'h0000_4000, 8'h80, 32'h0000_0100, 32'h00AB_CDEF, 21);
    for (int s = 0; s < 16; s++)
      run_case(32'h0001_0000 + s * 32'h100, 8'(s * 17), 32'h0050_0000 + s,
               32'h0700_0000 + s * 32'h11, s);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule